// File: doc/BRIEF.md
# Sequential Two's-Complement Shift-Add Multiplier

This block multiplies two N-bit operands over N clock cycles and returns a 2N-bit product. A register holds the running partial product, cleared to zero when an operation begins. Each cycle takes one bit of the multiplier, starting with the least significant. When that bit is 1, the multiplicand, shifted left by the bit's index, is added to the register; when it is 0, zero is added. Every addition is exactly 2N bits wide and any carry beyond that width is dropped.

In signed mode, the multiplicand is sign-extended to 2N bits before it is shifted. The multiplier's top bit has weight -2^(N-1), so the addend for that step is negated. A parameter selects unsigned mode instead. In that mode the multiplicand is zero-extended and every multiplier bit has positive weight.

A one-cycle start pulse launches an operation while the block is idle. The block then shows busy, and afterwards pulses done for one cycle. The product stays on its output until the next operation finishes.

Top module: `seq_mul`

## Requirements
- R1: After reset, busy_o and done_o are 0 and product_o is all zeros.
- R2: A start_i pulse sampled while idle captures both operands. busy_o is 1 from the next cycle for exactly WIDTH consecutive cycles.
- R3: done_o is 1 for exactly one cycle, the first cycle after busy_o falls, and is never 1 in two consecutive cycles.
- R4: With SIGNED_MODE=1, product_o equals the two's-complement product of mcand_i and mplier_i, as a 2N-bit two's-complement value. The multiplier bit at position WIDTH-1 carries weight -2^(WIDTH-1).
- R5: With SIGNED_MODE=0, product_o equals the unsigned product of both operands, with every bit of each operand having positive weight.
- R6: A start_i pulse while busy_o is 1 is ignored: the operation in flight keeps its operands and its WIDTH-cycle timing.
- R7: product_o changes only on the cycle that done_o rises, and holds its value at all other times, including during the next operation.
- R8: A zero operand gives a zero product. In signed mode, the most-negative value squared gives exactly +2^(2*WIDTH-2).
- R9: With WIDTH=4 and operands 4'b1011 and 4'b1101, signed mode gives 8'b00001111 and unsigned mode gives 8'b10001111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| mcand_i | input | WIDTH | Multiplicand |
| mplier_i | input | WIDTH | Multiplier |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when product_o is fresh |
| product_o | output | 2*WIDTH | Product, held between operations |

## Verification
The bench runs every 4-bit operand pair through a signed instance and an unsigned instance in parallel.

It covers the following cases:
- Negative multiplier top bit: a design that treats the top bit as positive gives results that are wrong by 2^WIDTH times the multiplicand.
- Negative multiplicand: a design that zero-extends it leaves garbage in the upper half of the product.
- Most-negative squared: this pair exposes an addend that is negated at too narrow a width.
- Start during busy: a design that restarts would stretch busy_o or return the product of the stray operands.
- Product held between operations: a design that clears or streams the register would show a changing product_o during the next operation.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             step_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             done_o
);
  mul_state_e       st_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;

  assign load_o = (st_q == ST_IDLE) && start_i;
  assign step_o = (st_q == ST_RUN);
  assign last_o = step_o && (idx_q == IDX_W'(WIDTH - 1));
  assign idx_o  = idx_q;
  assign busy_o = step_o;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (load_o) begin
        st_q  <= ST_RUN;
        idx_q <= '0;
      end else if (last_o) begin
        st_q  <= ST_IDLE;
        idx_q <= '0;
      end else if (step_o) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  AST_BUSY_STARTS_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (idx_q == '0)); // R2
  AST_BUSY_CONTINUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last_o) |=> busy_o); // R2
  AST_LAST_ENDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (!busy_o && done_o)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3
endmodule

// File: rtl/mul_addend.sv
module mul_addend #(
  parameter int WIDTH       = 8,
  parameter bit SIGNED_MODE = 1'b1,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1,
  localparam int PW    = 2 * WIDTH
) (
  input  logic [WIDTH-1:0] mcand_i,
  input  logic             bit_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             last_i,
  output logic [PW-1:0]    addend_o
);
  logic [PW-1:0] ext;
  logic [PW-1:0] shifted;

  generate
    if (SIGNED_MODE) begin : g_sext
      assign ext = {{WIDTH{mcand_i[WIDTH-1]}}, mcand_i};
    end else begin : g_zext
      assign ext = {{WIDTH{1'b0}}, mcand_i};
    end
  endgenerate

  assign shifted = ext << idx_i;

  always_comb begin
    if (!bit_i) begin
      addend_o = '0;
    end else if (SIGNED_MODE && last_i) begin
      // top multiplier bit weighs -2^(WIDTH-1)
      addend_o = (~shifted) + 1'b1;
    end else begin
      addend_o = shifted;
    end
  end
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int WIDTH       = 8,
  parameter bit SIGNED_MODE = 1'b1,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1,
  localparam int PW    = 2 * WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             last_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic [PW-1:0]    product_o
);
  logic [WIDTH-1:0] mcand_q;
  logic [WIDTH-1:0] mplier_q;
  logic [PW-1:0]    acc_q;
  logic [PW-1:0]    prod_q;
  logic [PW-1:0]    addend;
  logic [PW-1:0]    sum;

  mul_addend #(
    .WIDTH      (WIDTH),
    .SIGNED_MODE(SIGNED_MODE)
  ) u_addend (
    .mcand_i (mcand_q),
    .bit_i   (mplier_q[idx_i]),
    .idx_i   (idx_i),
    .last_i  (last_i),
    .addend_o(addend)
  );

  // carry out of the 2N-bit sum is dropped
  assign sum = acc_q + addend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
      prod_q   <= '0;
    end else begin
      if (load_i) begin
        mcand_q  <= mcand_i;
        mplier_q <= mplier_i;
        acc_q    <= '0;
      end else if (step_i) begin
        acc_q <= sum;
        if (last_i) prod_q <= sum;
      end
    end
  end

  assign product_o = prod_q;

  AST_OPERANDS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> ($stable(mcand_q) && $stable(mplier_q))); // R6
  AST_PRODUCT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i |=> $stable(prod_q)); // R7
  AST_LOAD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (acc_q == '0)); // R2
endmodule

// File: rtl/seq_mul.sv
module seq_mul #(
  parameter int WIDTH       = 8,
  parameter bit SIGNED_MODE = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic             load;
  logic             step;
  logic             last;
  logic [IDX_W-1:0] idx;

  mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .last_o (last),
    .idx_o  (idx),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  mul_datapath #(
    .WIDTH      (WIDTH),
    .SIGNED_MODE(SIGNED_MODE)
  ) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .step_i   (step),
    .last_i   (last),
    .idx_i    (idx),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .product_o(product_o)
  );

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o)); // R3
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !last) |=> busy_o); // R6
endmodule

// File: tb/sim_seq_mul.sv
`timescale 1ns/1ps
module sim_seq_mul;
  localparam int W  = 4;
  localparam int PW = 2 * W;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [W-1:0]  mcand_i = '0;
  logic [W-1:0]  mplier_i = '0;
  logic          busy_s, done_s, busy_u, done_u;
  logic [PW-1:0] prod_s, prod_u;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int busy_cnt_s = 0;
  int busy_cnt_u = 0;
  logic prev_done_s = 1'b0;
  logic [PW-1:0] last_s = '0;
  logic [PW-1:0] last_u = '0;

  logic [PW-1:0] exp_s_q[$];
  logic [PW-1:0] exp_u_q[$];
  string         tag_q[$];

  always #2 clk_i = ~clk_i;

  seq_mul #(.WIDTH(W), .SIGNED_MODE(1'b1)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .mcand_i(mcand_i), .mplier_i(mplier_i),
    .busy_o(busy_s), .done_o(done_s), .product_o(prod_s));

  seq_mul #(.WIDTH(W), .SIGNED_MODE(1'b0)) u1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .mcand_i(mcand_i), .mplier_i(mplier_i),
    .busy_o(busy_u), .done_o(done_u), .product_o(prod_u));

  task automatic check(input bit ok, input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: pops expected values when done pulses
  always @(negedge clk_i) begin
    if (rst_ni) begin
      cycles++;
      if (busy_s) busy_cnt_s++;
      if (busy_u) busy_cnt_u++;
      check(!(done_s && prev_done_s), "R3 done single pulse", PW'(done_s), '0);
      prev_done_s = done_s;
      if (done_s) begin
        string t;
        t = (tag_q.size() > 0) ? tag_q.pop_front() : "R4";
        check(busy_cnt_s == W, "R2 busy length signed", PW'(busy_cnt_s), PW'(W));
        check(!busy_s, "R3 busy low at done", PW'(busy_s), '0);
        if (exp_s_q.size() > 0) begin
          logic [PW-1:0] e;
          e = exp_s_q.pop_front();
          check(prod_s == e, {t, " signed product"}, prod_s, e);
          last_s = e;
        end else check(1'b0, "R3 unexpected done", prod_s, '0);
        busy_cnt_s = 0;
      end
      if (done_u) begin
        check(busy_cnt_u == W, "R2 busy length unsigned", PW'(busy_cnt_u), PW'(W));
        if (exp_u_q.size() > 0) begin
          logic [PW-1:0] e;
          e = exp_u_q.pop_front();
          check(prod_u == e, "R5 unsigned product", prod_u, e);
          last_u = e;
        end else check(1'b0, "R3 unexpected done", prod_u, '0);
        busy_cnt_u = 0;
      end
      if (cycles > 100000) begin
        check(1'b0, "watchdog", '0, '0);
        finish_sim();
      end
    end
  end

  // driver: launch one operation and push expected results
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit poke, input string tag);
    logic [PW-1:0] es, eu;
    es = {{W{a[W-1]}}, a} * {{W{b[W-1]}}, b};
    eu = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    exp_s_q.push_back(es);
    exp_u_q.push_back(eu);
    tag_q.push_back(tag);
    start_i  = 1'b1;
    mcand_i  = a;
    mplier_i = b;
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke) begin
      // stray start while busy: R6
      @(negedge clk_i);
      start_i  = 1'b1;
      mcand_i  = ~a;
      mplier_i = b + 4'd5;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    do @(negedge clk_i); while (!done_s);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(!busy_s && !done_s && prod_s == '0, "R1 reset signed", prod_s, '0);
    check(!busy_u && !done_u && prod_u == '0, "R1 reset unsigned", prod_u, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run_op(4'b1011, 4'b1101, 1'b0, "R9");
    check(prod_s == 8'b00001111, "R9 signed example", prod_s, 8'b00001111);
    check(prod_u == 8'b10001111, "R9 unsigned example", prod_u, 8'b10001111);

    run_op(4'b1000, 4'b1000, 1'b0, "R8");
    check(prod_s == 8'd64, "R8 most-negative squared", prod_s, 8'd64);
    run_op(4'b0000, 4'b0111, 1'b0, "R8");
    check(prod_s == '0 && prod_u == '0, "R8 zero multiplicand", prod_s, '0);
    run_op(4'b1001, 4'b0000, 1'b0, "R8");
    check(prod_s == '0 && prod_u == '0, "R8 zero multiplier", prod_u, '0);

    run_op(4'b0110, 4'b1010, 1'b1, "R6");

    // R7: held while idle and through the next operation
    repeat (3) @(negedge clk_i);
    check(prod_s == last_s, "R7 held idle signed", prod_s, last_s);
    check(prod_u == last_u, "R7 held idle unsigned", prod_u, last_u);
    start_i = 1'b1; mcand_i = 4'b0011; mplier_i = 4'b0101;
    exp_s_q.push_back(8'd15); exp_u_q.push_back(8'd15); tag_q.push_back("R4");
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    check(busy_s && prod_s == last_s, "R7 held during run", prod_s, last_s);
    do @(negedge clk_i); while (!done_s);

    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        run_op(W'(a), W'(b), 1'b0, "R4");
      end
    end

    repeat (2) @(negedge clk_i);
    check(exp_s_q.size() == 0 && exp_u_q.size() == 0, "R3 all results seen",
          PW'(exp_s_q.size()), '0);
    finish_sim();
  end
endmodule